// File: doc/BRIEF.md
# Power-Up Configuration Load Sequencer

This block runs the start-up of a programmable clock divider. After reset it brings up the internal oscillator. It then parks the prescaler and divider working registers at their slowest setting and holds for a fixed number of oscillator cycles so the oscillator can settle. At the end of that hold it samples the shared I/O pin once. A high level selects programming mode: the pin is released and the clock output stays off. A low level selects operating mode. In operating mode the sequencer reads two stored configuration words over a request/acknowledge handshake, the mode word first and the divisor word second. It copies each word into its working register, then enables the clock output and raises a done flag.

The same sequence runs on every reset. This covers both first power application and return from power-down. The storage itself is outside the block. Only the handshake is visible here: a request, a one-bit word select, an acknowledge, and the data that is valid with the acknowledge.

Top module: `cfg_boot_seq`

## Requirements
- R1: While reset is asserted, every output is low or zero. This covers oscillator enable, storage request, word select, output enable, programming flag, done flag and both working registers.
- R2: On the first clock edge after reset release, the oscillator enable rises and then stays high until the next reset. On the second edge, the divisor register loads all ones (divide by the largest value) and the mode register loads all zeros (prescaler divide-by-4, no bypass).
- R3: The settling hold lasts exactly WAIT_CYC cycles. The storage request is low after edge WAIT_CYC+1 and, in operating mode, first high after edge WAIT_CYC+2, counting edges from reset release.
- R4: The pin is sampled only at edge WAIT_CYC+2. If it is high, the programming flag rises at that edge and stays set. In that case no request is ever issued, the output enable stays low, and the working registers keep their slowest values. The pin level on any other edge has no effect.
- R5: In operating mode the request is held with word select 0 until an acknowledge. The mode register captures the data on the acknowledged edge.
- R6: After the mode word, the request continues with word select 1 until an acknowledge. The divisor register captures the data on that edge.
- R7: The edge that captures the divisor word drops the request and raises both output enable and done. Both stay high until the next reset.
- R8: An acknowledge that arrives while the request is low changes neither working register and does not advance the sequence.
- R9: Asserting reset at any point in the sequence returns the block to the R1 state. The full sequence then runs again from the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator-domain clock |
| rst_ni | input | 1 | Active-low reset (power-on or power-down recovery) |
| pin_i | input | 1 | Synchronised level of the shared I/O pin |
| nv_ack_i | input | 1 | Storage acknowledge; data valid in this cycle |
| nv_data_i | input | WORD_W | Stored word returned by storage |
| osc_en_o | output | 1 | Internal oscillator enable |
| nv_req_o | output | 1 | Storage read request |
| nv_addr_o | output | 1 | Word select: 0 mode word, 1 divisor word |
| mode_word_o | output | WORD_W | Working prescaler/mode register |
| div_word_o | output | WORD_W | Working divisor register |
| out_en_o | output | 1 | Clock output drive enable |
| prog_mode_o | output | 1 | Programming mode selected; pin released |
| done_o | output | 1 | Boot complete in operating mode |

## Verification
Two events can land on the same edge: the single pin sample that closes the settling hold, and a stray storage acknowledge. The bench drives a spurious acknowledge with junk data on every hold cycle, including the final one. It drives the pin to the opposite level on all hold cycles except that last one. The bench then judges three things. The mode choice must follow only the last-cycle level. No junk word may reach a working register. The first real request must appear exactly one edge after the sample. Acknowledges are also repeated after both the operating and programming end states, to confirm the registers hold.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic [2:0] {
        ST_INIT    = 3'd0,
        ST_OSC     = 3'd1,
        ST_WAIT    = 3'd2,
        ST_FETCH_M = 3'd3,
        ST_FETCH_D = 3'd4,
        ST_RUN     = 3'd5,
        ST_PROG    = 3'd6
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/cbs_stab_timer.sv
module cbs_stab_timer #(
    parameter int unsigned WAIT_CYC = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic last_o
);
    localparam int unsigned CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WAIT_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // counts cycles spent in the hold; cleared whenever the hold is not active
    always_comb begin
        cnt_d = '0;
        if (run_i) begin
            cnt_d = CNT_W'(cnt_q + 1'b1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = run_i && (cnt_q == LAST_CNT);

endmodule

// File: rtl/cbs_cfg_regs.sv
module cbs_cfg_regs #(
    parameter int unsigned WORD_W = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              force_max_i,
    input  logic              ld_mode_i,
    input  logic              ld_div_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] mode_o,
    output logic [WORD_W-1:0] div_o
);
    // slowest setting: prescaler divide-by-4 without bypass, divisor at its top code
    localparam logic [WORD_W-1:0] SLOW_MODE = '0;
    localparam logic [WORD_W-1:0] SLOW_DIV  = '1;

    typedef struct packed {
        logic [WORD_W-1:0] mode;
        logic [WORD_W-1:0] div;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (force_max_i) begin
            bank_d.mode = SLOW_MODE;
            bank_d.div  = SLOW_DIV;
        end
        if (ld_mode_i) begin
            bank_d.mode = data_i;
        end
        if (ld_div_i) begin
            bank_d.div = data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign mode_o = bank_q.mode;
    assign div_o  = bank_q.div;

endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
    import cbs_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 1024,
    parameter int unsigned WORD_W   = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pin_i,
    input  logic              nv_ack_i,
    input  logic [WORD_W-1:0] nv_data_i,
    output logic              osc_en_o,
    output logic              nv_req_o,
    output logic              nv_addr_o,
    output logic [WORD_W-1:0] mode_word_o,
    output logic [WORD_W-1:0] div_word_o,
    output logic              out_en_o,
    output logic              prog_mode_o,
    output logic              done_o
);
    seq_regs_t seq_d, seq_q;
    logic      hold_last;
    logic      in_hold;
    logic      force_max;
    logic      ld_mode;
    logic      ld_div;

    assign in_hold   = (seq_q.state == ST_WAIT);
    assign force_max = (seq_q.state == ST_OSC);
    assign ld_mode   = (seq_q.state == ST_FETCH_M) && nv_ack_i;
    assign ld_div    = (seq_q.state == ST_FETCH_D) && nv_ack_i;

    cbs_stab_timer #(
        .WAIT_CYC(WAIT_CYC)
    ) timer_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (in_hold),
        .last_o (hold_last)
    );

    cbs_cfg_regs #(
        .WORD_W(WORD_W)
    ) regs_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .force_max_i (force_max),
        .ld_mode_i   (ld_mode),
        .ld_div_i    (ld_div),
        .data_i      (nv_data_i),
        .mode_o      (mode_word_o),
        .div_o       (div_word_o)
    );

    // boot order: init, oscillator on, park at slowest, hold, sample pin, fetch, run
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_INIT:    seq_d.state = ST_OSC;
            ST_OSC:     seq_d.state = ST_WAIT;
            ST_WAIT: begin
                if (hold_last) begin
                    seq_d.state = pin_i ? ST_PROG : ST_FETCH_M;
                end
            end
            ST_FETCH_M: begin
                if (nv_ack_i) begin
                    seq_d.state = ST_FETCH_D;
                end
            end
            ST_FETCH_D: begin
                if (nv_ack_i) begin
                    seq_d.state = ST_RUN;
                end
            end
            ST_RUN:     seq_d.state = ST_RUN;
            ST_PROG:    seq_d.state = ST_PROG;
            default:    seq_d.state = ST_INIT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{state: ST_INIT};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign osc_en_o    = (seq_q.state != ST_INIT);
    assign nv_req_o    = (seq_q.state == ST_FETCH_M) || (seq_q.state == ST_FETCH_D);
    assign nv_addr_o   = (seq_q.state == ST_FETCH_D);
    assign out_en_o    = (seq_q.state == ST_RUN);
    assign done_o      = (seq_q.state == ST_RUN);
    assign prog_mode_o = (seq_q.state == ST_PROG);

endmodule

// File: rtl/cfg_boot_seq_chk.sv
module cfg_boot_seq_chk #(
    parameter int unsigned WORD_W = 9
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              nv_ack_i,
    input logic              osc_en_o,
    input logic              nv_req_o,
    input logic              nv_addr_o,
    input logic [WORD_W-1:0] mode_word_o,
    input logic [WORD_W-1:0] div_word_o,
    input logic              out_en_o,
    input logic              prog_mode_o,
    input logic              done_o
);
    // R2
    osc_stays_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        osc_en_o |=> osc_en_o);

    // R2
    slow_div_during_mode_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nv_req_o && !nv_addr_o) |-> (div_word_o == {WORD_W{1'b1}}));

    // R4
    prog_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prog_mode_o |-> (!out_en_o && !nv_req_o && !done_o));

    // R5
    req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nv_req_o && !nv_ack_i) |=> (nv_req_o && $stable(nv_addr_o)));

    // R6
    addr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(nv_addr_o) |-> $past(nv_req_o && !nv_addr_o && nv_ack_i));

    // R7
    out_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(out_en_o) |-> $past(nv_req_o && nv_addr_o && nv_ack_i));

    // R7
    done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (done_o && out_en_o && !nv_req_o));

    // R8
    settled_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_en_o || prog_mode_o) |=> ($stable(mode_word_o) && $stable(div_word_o)));

endmodule

bind cfg_boot_seq cfg_boot_seq_chk #(
    .WORD_W(WORD_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nv_ack_i    (nv_ack_i),
    .osc_en_o    (osc_en_o),
    .nv_req_o    (nv_req_o),
    .nv_addr_o   (nv_addr_o),
    .mode_word_o (mode_word_o),
    .div_word_o  (div_word_o),
    .out_en_o    (out_en_o),
    .prog_mode_o (prog_mode_o),
    .done_o      (done_o)
);

// File: tb/cfg_boot_seq_tb_top.sv
module cfg_boot_seq_tb_top;
    localparam int W  = 16;
    localparam int WW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pin = 1'b0;
    logic          ack = 1'b0;
    logic [WW-1:0] data = '0;
    logic          osc_en, req, addr, out_en, prog, done;
    logic [WW-1:0] mode_w, div_w;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cfg_boot_seq #(.WAIT_CYC(W), .WORD_W(WW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .nv_ack_i(ack), .nv_data_i(data),
        .osc_en_o(osc_en), .nv_req_o(req), .nv_addr_o(addr),
        .mode_word_o(mode_w), .div_word_o(div_w),
        .out_en_o(out_en), .prog_mode_o(prog), .done_o(done)
    );

    function automatic logic [WW-1:0] slow_div();
        return '1;
    endfunction

    function automatic logic [WW-1:0] slow_mode();
        return '0;
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_checks(input string rq);
        chk(rq, "osc_en", 32'(osc_en), 0);
        chk(rq, "req", 32'(req), 0);
        chk(rq, "addr", 32'(addr), 0);
        chk(rq, "out_en", 32'(out_en), 0);
        chk(rq, "prog", 32'(prog), 0);
        chk(rq, "done", 32'(done), 0);
        chk(rq, "mode_word", 32'(mode_w), 0);
        chk(rq, "div_word", 32'(div_w), 0);
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ack = 1'b0;
        pin = 1'b0;
        repeat (2) @(negedge clk);
        idle_checks("R1");
        rst_n = 1'b1;
    endtask

    task automatic stray_acks(input int n, input logic [WW-1:0] em, input logic [WW-1:0] ed,
                              input logic e_out, input string rq);
        for (int i = 0; i < n; i++) begin
            ack = 1'b1;
            data = WW'($urandom);
            step();
        end
        ack = 1'b0;
        chk(rq, "mode_word after stray ack", 32'(mode_w), 32'(em));
        chk(rq, "div_word after stray ack", 32'(div_w), 32'(ed));
        chk(rq, "out_en after stray ack", 32'(out_en), 32'(e_out));
        chk(rq, "done after stray ack", 32'(done), 32'(e_out));
    endtask

    task automatic boot(input logic lvl, input logic [WW-1:0] mv, input logic [WW-1:0] dv,
                        input int lm, input int ld, input bit stray);
        pin = ~lvl;
        step();
        chk("R2", "osc_en after edge 1", 32'(osc_en), 1);
        chk("R2", "div before park", 32'(div_w), 0);
        step();
        chk("R2", "div parked", 32'(div_w), 32'(slow_div()));
        chk("R2", "mode parked", 32'(mode_w), 32'(slow_mode()));
        for (int k = 3; k <= W + 2; k++) begin
            pin = (k == W + 2) ? lvl : ~lvl;
            ack = stray;
            data = WW'($urandom);
            step();
            if (k == W + 1) chk("R3", "req still low at end of hold", 32'(req), 0);
        end
        ack = 1'b0;
        pin = 1'($urandom);
        if (lvl) begin
            chk("R4", "prog flag", 32'(prog), 1);
            chk("R4", "req in prog", 32'(req), 0);
            chk("R4", "out_en in prog", 32'(out_en), 0);
            chk("R4", "div kept slow", 32'(div_w), 32'(slow_div()));
            stray_acks(4, slow_mode(), slow_div(), 1'b0, "R8");
            chk("R4", "prog flag held", 32'(prog), 1);
        end else begin
            chk("R3", "req high after sample edge", 32'(req), 1);
            chk("R5", "select mode word", 32'(addr), 0);
            chk("R4", "prog stays low", 32'(prog), 0);
            for (int i = 0; i < lm; i++) step();
            chk("R5", "req held before ack", 32'(req), 1);
            ack = 1'b1;
            data = mv;
            step();
            ack = 1'b0;
            data = WW'($urandom);
            chk("R5", "mode word captured", 32'(mode_w), 32'(mv));
            chk("R6", "select divisor word", 32'(addr), 1);
            chk("R6", "req continues", 32'(req), 1);
            chk("R6", "out_en not yet", 32'(out_en), 0);
            for (int i = 0; i < ld; i++) step();
            ack = 1'b1;
            data = dv;
            step();
            ack = 1'b0;
            chk("R6", "divisor word captured", 32'(div_w), 32'(dv));
            chk("R7", "out_en raised", 32'(out_en), 1);
            chk("R7", "done raised", 32'(done), 1);
            chk("R7", "req dropped", 32'(req), 0);
            stray_acks(4, mv, dv, 1'b1, "R8");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        // R1 state during reset, then directed boots
        enter_reset();
        boot(1'b0, 9'h0A5, 9'h000, 0, 0, 1'b1);
        enter_reset();
        boot(1'b0, 9'h1FF, 9'h1FF, 2, 3, 1'b0);
        enter_reset();
        boot(1'b1, 9'h000, 9'h000, 0, 0, 1'b1);
        // R9: reset partway through the hold and partway through fetch
        for (int a = 0; a < 2; a++) begin
            enter_reset();
            repeat ((a == 0) ? 5 : W + 3) step();
            rst_n = 1'b0;
            @(negedge clk);
            idle_checks("R9");
            rst_n = 1'b1;
            boot(1'b0, 9'h13C, 9'h0F0, 1, 1, 1'b1);
        end
        // random boots
        for (int r = 0; r < 8; r++) begin
            enter_reset();
            boot(1'($urandom), WW'($urandom), WW'($urandom),
                 int'($urandom % 4), int'($urandom % 4), 1'($urandom));
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule